// File: doc/BRIEF.md
# Fourth-Order Decimating Filter for a One-Bit Modulator Stream

This block turns the one-bit output of a delta-sigma modulator into 20-bit two's-complement conversion words at a fixed rate. Each accepted modulator bit counts as +1 (bit high) or -1 (bit low). The bits pass through four cascaded integrators, are decimated by a fixed ratio `DECIM`, and then pass through four cascaded differencing stages. The raw filter value spans ±DECIM⁴. It is rescaled so that the full-scale range corresponds to ±2¹⁹, and it is clipped to the 20-bit code range rather than wrapping.

The modulator feeds one bit per asserted `mod_en`. Cycles with `mod_en` low leave the filter untouched. With the default ratio of 15360 and a bit rate of one eighth of a 1.2288 MHz system clock, the block produces ten words per second.

A fourth-order filter only gives a meaningful word once four decimation periods of input have passed through it. For that reason the first three words after reset are dropped silently. The first strobe therefore carries an already settled result.

Top module: `sinc4_decimator`

## Requirements
- R1: With a periodic input stream whose period divides `DECIM` and that has been applied for at least four output words, the delivered code is within 2 LSB of S·2¹⁹/DECIM. Here S is the number of high bits minus the number of low bits in any `DECIM` consecutive accepted samples (bit 1 = +1, bit 0 = -1).
- R2: A stream with equal numbers of high and low bits per period yields exactly code 0x00000.
- R3: Codes never wrap. A stream of all ones (positive full scale) gives exactly 0x7FFFF, and a stream of all zeros gives exactly 0x80000.
- R4: `result_valid` is a single-cycle pulse, issued once per `DECIM` accepted samples. After reset, 10·`DECIM` accepted samples give exactly 7 pulses.
- R5: No pulse occurs before 4·`DECIM` samples have been accepted since reset. The first pulse is high in the second cycle after the clock edge that accepts the 4·`DECIM`-th sample.
- R6: Cycles with `mod_en` low are ignored. A stream with idle cycles inserted between samples gives the same code as the same samples without gaps.
- R7: During reset and until the first pulse, `result` is 0x00000 and `result_valid` is low.
- R8: The first delivered word after reset is fully settled. For a stream that is constant since reset, it equals the steady-state code.
- R9: `result` holds its value in every cycle in which `result_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| mod_en | input | 1 | Accept `mod_bit` in this cycle |
| result | output | 20 | Two's-complement conversion word |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The bench runs a small ratio and sweeps every ones-density whose period divides it. This includes both extremes, where a design with no clipping would wrap full scale to the opposite sign. It also includes the balanced cases, where a rounding or offset slip would show up as a nonzero code. The exact cycle of the first strobe is checked, with the stream halted one sample short of 4·`DECIM`. Gating that releases an unsettled word, or that drops one word too many, would move that strobe or change the pulse count. Idle gaps inserted into the stream catch a filter that integrates while `mod_en` is low.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

    localparam int ORDER  = 4;
    localparam int CODE_W = 20;

    typedef logic signed [CODE_W-1:0] code_t;

    localparam code_t CODE_MAX = 20'sh7FFFF;
    localparam code_t CODE_MIN = 20'sh80000;

    // word handed to the output port
    typedef struct packed {
        logic  valid;
        code_t code;
    } word_t;

    // outcome of the range check in the scaler
    typedef enum logic [1:0] {
        SAT_NONE,
        SAT_HIGH,
        SAT_LOW
    } sat_e;

    // bits needed so that integrators never lose information modulo 2^W
    function automatic int acc_width(input int ratio);
        return ORDER * $clog2(ratio) + 1;
    endfunction

    // rounded 2^(shift+CODE_W-1) / ratio^ORDER
    function automatic logic [127:0] cic_gain(input int ratio, input int shift);
        logic [127:0] dc;
        logic [127:0] num;
        dc = 128'd1;
        for (int i = 0; i < ORDER; i++) begin
            dc = dc * 128'(ratio);
        end
        num = 128'd1 << (shift + CODE_W - 1);
        return (num + (dc >> 1)) / dc;
    endfunction

endpackage

// File: rtl/cic_integrators.sv
module cic_integrators
    import sinc4_pkg::*;
#(
    parameter int ACC_W = 57
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] acc_out
);

    logic signed [ACC_W-1:0] step;
    assign step = bit_in ? ACC_W'(1) : '1;

    for (genvar s = 0; s < ORDER; s++) begin : g_stage
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] addend;
        if (s == 0) begin : g_first
            assign addend = step;
        end else begin : g_next
            assign addend = g_stage[s-1].acc;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                acc <= '0;
            end else if (en) begin
                acc <= acc + addend;   // modulo 2^ACC_W by design
            end
        end
    end

    assign acc_out = g_stage[ORDER-1].acc;

    // idle cycles must not move the filter state
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_out));

endmodule

// File: rtl/cic_combs.sv
module cic_combs
    import sinc4_pkg::*;
#(
    parameter int ACC_W = 57
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout,
    output logic                    dout_valid
);

    for (genvar s = 0; s < ORDER; s++) begin : g_stage
        logic signed [ACC_W-1:0] stage_in;
        logic signed [ACC_W-1:0] held;
        logic signed [ACC_W-1:0] diff;
        if (s == 0) begin : g_first
            assign stage_in = din;
        end else begin : g_next
            assign stage_in = g_stage[s-1].diff;
        end
        assign diff = stage_in - held;
        always_ff @(posedge clk) begin
            if (rst) begin
                held <= '0;
            end else if (tick) begin
                held <= stage_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= tick;
            if (tick) begin
                dout <= g_stage[ORDER-1].diff;
            end
        end
    end

    p_comb_single_r4: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> !dout_valid);

endmodule

// File: rtl/cic_scale_sat.sv
module cic_scale_sat
    import sinc4_pkg::*;
#(
    parameter int                ACC_W  = 57,
    parameter int                GAIN_W = 24,
    parameter int                SHIFT  = 56,
    parameter logic [GAIN_W-1:0] GAIN   = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    keep,
    input  logic signed [ACC_W-1:0] din,
    output word_t                   word
);

    localparam int PROD_W = ACC_W + GAIN_W + 1;
    localparam logic signed [GAIN_W:0]   GAIN_S = {1'b0, GAIN};
    localparam logic signed [PROD_W-1:0] HI     = PROD_W'(CODE_MAX);
    localparam logic signed [PROD_W-1:0] LO     = PROD_W'(CODE_MIN);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    sat_e                     sat;
    logic                     deliver;

    assign prod    = PROD_W'(din) * PROD_W'(GAIN_S);
    assign scaled  = prod >>> SHIFT;
    assign deliver = in_valid & keep;

    always_comb begin
        if (scaled > HI) begin
            sat = SAT_HIGH;
        end else if (scaled < LO) begin
            sat = SAT_LOW;
        end else begin
            sat = SAT_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else begin
            word.valid <= deliver;
            if (deliver) begin
                unique case (sat)
                    SAT_HIGH: word.code <= CODE_MAX;
                    SAT_LOW:  word.code <= CODE_MIN;
                    default:  word.code <= code_t'(scaled);
                endcase
            end
        end
    end

    // sign of the filter value survives into the code (no wrap)
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        word.valid |-> (($past(din) >= 0) == (word.code[CODE_W-1] == 1'b0)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !word.valid |-> $stable(word.code));

endmodule

// File: rtl/sinc4_decimator.sv
module sinc4_decimator
    import sinc4_pkg::*;
#(
    parameter int DECIM = 15360
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mod_bit,
    input  logic        mod_en,
    output logic [19:0] result,
    output logic        result_valid
);

    localparam int           ACC_W     = acc_width(DECIM);
    localparam int           SHIFT     = ACC_W - 1;
    localparam int           GAIN_W    = CODE_W + ORDER;
    localparam logic [127:0] GAIN_FULL = cic_gain(DECIM, SHIFT);
    localparam logic [GAIN_W-1:0] GAIN = GAIN_FULL[GAIN_W-1:0];
    localparam int           PHASE_W   = $clog2(DECIM);
    localparam int           FILL_W    = $clog2(ORDER);
    localparam int           SEEN_MAX  = ORDER * DECIM;
    localparam int           SEEN_W    = $clog2(SEEN_MAX + 1);

    logic [PHASE_W-1:0]      phase;
    logic                    tick_q;
    logic [FILL_W-1:0]       fill;
    logic                    keep;
    logic signed [ACC_W-1:0] integ_out;
    logic signed [ACC_W-1:0] comb_out;
    logic                    comb_valid;
    word_t                   word;

    // decimation phase over accepted samples
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= mod_en && (phase == PHASE_W'(DECIM - 1));
            if (mod_en) begin
                phase <= (phase == PHASE_W'(DECIM - 1)) ? '0 : phase + 1'b1;
            end
        end
    end

    // drop the words produced while the filter is still filling
    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (comb_valid && !keep) begin
            fill <= fill + 1'b1;
        end
    end
    assign keep = (fill == FILL_W'(ORDER - 1));

    cic_integrators #(.ACC_W(ACC_W)) u_integ (
        .clk    (clk),
        .rst    (rst),
        .en     (mod_en),
        .bit_in (mod_bit),
        .acc_out(integ_out)
    );

    cic_combs #(.ACC_W(ACC_W)) u_comb (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_q),
        .din       (integ_out),
        .dout      (comb_out),
        .dout_valid(comb_valid)
    );

    cic_scale_sat #(
        .ACC_W (ACC_W),
        .GAIN_W(GAIN_W),
        .SHIFT (SHIFT),
        .GAIN  (GAIN)
    ) u_scale (
        .clk     (clk),
        .rst     (rst),
        .in_valid(comb_valid),
        .keep    (keep),
        .din     (comb_out),
        .word    (word)
    );

    assign result       = word.code;
    assign result_valid = word.valid;

    // accepted-sample count since reset, for the settling check only
    logic [SEEN_W-1:0] seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (mod_en && seen != SEEN_W'(SEEN_MAX)) begin
            seen <= seen + 1'b1;
        end
    end

    p_no_early_valid_r5: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (seen == SEEN_W'(SEEN_MAX)));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    p_reset_state_r7: assert property (@(posedge clk)
        rst |=> (!result_valid && result == '0));

endmodule

// File: tb/sinc4_decimator_tb.sv
module sinc4_decimator_tb;

    localparam int R = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_bit = 1'b0;
    logic        mod_en = 1'b0;
    logic [19:0] result;
    logic        result_valid;

    int checks = 0;
    int errors = 0;
    int nvalid = 0;
    int cyc = 0;
    logic signed [19:0] last_code = '0;

    sinc4_decimator #(.DECIM(R)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .mod_bit     (mod_bit),
        .mod_en      (mod_en),
        .result      (result),
        .result_valid(result_valid)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        if (result_valid) begin
            nvalid++;
            last_code = result;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit b, input bit e);
        @(negedge clk);
        mod_bit = b;
        mod_en  = e;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mod_en = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        nvalid = 0;
    endtask

    // periodic stream: first k of every p samples high, gap idle cycles between samples
    task automatic run_density(input int p, input int k, input int gap, input string req);
        int start;
        int idx;
        int s;
        real ideal;
        real d;
        int act;
        start = nvalid;
        idx = 0;
        while (nvalid - start < 5) begin
            drive((idx % p) < k, 1'b1);
            idx++;
            for (int g = 0; g < gap; g++) drive(1'b0, 1'b0);
        end
        s = (R / p) * (2 * k - p);
        ideal = real'(s) * 524288.0 / real'(R);
        if (ideal > 524287.0) ideal = 524287.0;
        if (ideal < -524288.0) ideal = -524288.0;
        act = int'(last_code);
        d = real'(act) - ideal;
        if (s == 0)
            check(act == 0, "R2 balanced stream", act, 0);
        else if (k == p)
            check(act == 524287, "R3 clip high", act, 524287);
        else if (k == 0)
            check(act == -524288, "R3 clip low", act, -524288);
        else
            check(d <= 2.0 && d >= -2.0, req, act, int'(ideal));
    endtask

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        check(result == 20'h0 && !result_valid, "R7 reset state", int'(result), 0);
        rst = 1'b0;
        nvalid = 0;

        // R5/R8: exact first-strobe timing, all ones since reset
        for (int i = 0; i < 4 * R - 1; i++) drive(1'b1, 1'b1);
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b0);
        check(nvalid == 0, "R5 no strobe before 4R samples", nvalid, 0);
        check(result == 20'h0, "R7 result zero before first strobe", int'(result), 0);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        check(result_valid == 1'b0, "R5 strobe not at T+1", int'(result_valid), 0);
        drive(1'b0, 1'b0);
        check(result_valid == 1'b0, "R5 strobe not at T+2 minus", int'(result_valid), 0);
        drive(1'b0, 1'b0);
        check(result_valid == 1'b1, "R5 strobe two cycles after 4R-th sample", int'(result_valid), 1);
        check(result == 20'h7FFFF, "R8 first word settled (R3 clip high)", int'(result), 'h7FFFF);
        drive(1'b0, 1'b0);
        check(result_valid == 1'b0, "R4 strobe lasts one cycle", int'(result_valid), 0);
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b0);
        check(result == 20'h7FFFF, "R9 result held while idle", int'(result), 'h7FFFF);
        check(nvalid == 1, "R6 idle cycles produce no words", nvalid, 1);

        // R4: pulse count over 10R samples with gaps
        do_reset();
        for (int i = 0; i < 10 * R; i++) begin
            drive(i[0], 1'b1);
            drive(1'b0, 1'b0);
        end
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b0);
        check(nvalid == 7, "R4 pulses over 10R samples", nvalid, 7);

        // R1/R2/R3: sweep every density with a period dividing R
        for (int pi = 0; pi < 6; pi++) begin
            int p;
            case (pi)
                0: p = 1;
                1: p = 2;
                2: p = 3;
                3: p = 4;
                4: p = 6;
                default: p = 12;
            endcase
            for (int k = 0; k <= p; k++) run_density(p, k, 0, "R1 density code");
        end

        // R6: gapped streams match the ungapped expectation
        run_density(4, 3, 2, "R6 gapped stream 3/4");
        run_density(3, 1, 1, "R6 gapped stream 1/3");
        run_density(12, 7, 3, "R6 gapped stream 7/12");
        run_density(2, 1, 1, "R6 gapped balanced");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule